// File: doc/BRIEF.md
# Zero-Cross Synchronized Triac Gate Timer

The block fires a short, active-high triac gate pulse at a programmable point inside each half-cycle of the AC line. A zero-crossing detector output enters through a two-flop synchronizer. Each rising edge of that input restarts a 16-bit phase counter from zero. The counter advances once every `PRESCALE` system clocks. The gate output is high while the count lies inside a window set by an on-compare value and an off-compare value.

Software loads a new window into a pair of shadow registers in one of two ways. The first is an 8-bit brightness setting, which the block turns into compare values itself. The second is a raw pair of compare values. The shadow pair moves into the active pair only on a zero-crossing edge, so a half-cycle in progress is never disturbed, and a hold input can hold that transfer back while software updates the shadow pair.

When zero-crossings are present, the counter never reaches its top. If it does overflow, the line is taken as lost. The block then sets a sticky fault flag and blanks the gate until the next zero-crossing comes in.

Top module: `triac_phase_ctrl`

## Requirements
- R1: After reset, `gate_out` and `fault_flag` are low. The active compare values are zero, so no pulse can come out before the first zero-crossing has loaded a window.
- R2: `zc_in` passes through two synchronizer flops. If `zc_in` rises before clock edge 1, the counter is cleared at edge 3. It then advances by one every `PRESCALE` (default 8) clocks, so count value c is first held after edge 3 + 8c.
- R3: `gate_out` is high exactly while the active on-compare ≤ count < active off-compare. It is high for 8 × (off − on) clocks.
- R4: With `use_setting` = 1, a shadow write stores on = (255 − `setting`) × 192 and off = on + 60. A higher setting fires earlier.
- R5: With `use_setting` = 0, a shadow write stores `on_raw` and `off_raw` unchanged.
- R6: When the active on-compare is greater than or equal to the active off-compare, `gate_out` stays low for the whole half-cycle.
- R7: The shadow values become active only on a synchronized zero-crossing edge. A write made in the middle of a half-cycle leaves the pulse of that half-cycle unchanged.
- R8: While `xfer_hold` is 1, a zero-crossing edge leaves the active values unchanged. The next edge seen with `xfer_hold` = 0 loads the shadow pair.
- R9: When the counter advances past all-ones, it wraps to zero. On that clock `fault_flag` is set and the gate is blanked, so `gate_out` stays low even while the count is inside the window.
- R10: Blanking ends at the first zero-crossing edge after the fault. `fault_flag` stays set through that edge.
- R11: A `fault_clr` pulse clears `fault_flag` on the next clock. A new overflow in the same clock takes priority over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| zc_in | input | 1 | Asynchronous zero-crossing detector output |
| use_setting | input | 1 | 1: derive the window from `setting`; 0: use the raw values |
| setting | input | SET_W (8) | Brightness setting, 0 to 255 |
| on_raw | input | CNT_W (16) | Raw on-compare value |
| off_raw | input | CNT_W (16) | Raw off-compare value |
| shadow_we | input | 1 | Write strobe for the shadow window |
| xfer_hold | input | 1 | Hold back the shadow-to-active transfer |
| fault_clr | input | 1 | Clear the overflow fault flag |
| gate_out | output | 1 | Active-high triac gate pulse |
| fault_flag | output | 1 | Sticky flag for lost zero-crossings |

## Verification
A vector table measures the gate's rise and fall clocks against the zero-crossing edge for several kinds of window. Setting-derived windows check the brightness arithmetic. Raw windows of 1 tick and 300 ticks separate the prescaler timing from the compare logic. Equal and reversed compare pairs must produce no pulse. Directed runs cover the rest: a mid-cycle shadow write must leave the current rise time unchanged, the hold input must keep the old window across an edge, and a reduced-width instance is run into overflow to show that the gate is blanked inside its window, that a zero-crossing releases it, and that the flag stays set until it is cleared.

// File: rtl/triac_pkg.sv
package triac_pkg;

  // Phase-count at which the gate fires for a brightness value.
  function automatic int unsigned turn_on_point(input int unsigned level,
                                                input int unsigned full_scale,
                                                input int unsigned step);
    return (full_scale - level) * step;
  endfunction

  // True when the count sits inside a non-empty [on, off) window.
  function automatic logic in_window(input int unsigned count,
                                     input int unsigned on_v,
                                     input int unsigned off_v);
    return (on_v < off_v) && (count >= on_v) && (count < off_v);
  endfunction

endpackage

// File: rtl/zc_edge_sync.sv
module zc_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic zc_in,
  output logic zc_rise
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= zc_in;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign zc_rise = sync_q & ~prev_q;
endmodule

// File: rtl/phase_counter.sv
module phase_counter #(
  parameter int CNT_W    = 16,
  parameter int PRESCALE = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  output logic [CNT_W-1:0] count,
  output logic             tick,
  output logic             ovf
);
  localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PRE_W-1:0] PRE_MAX = PRE_W'(PRESCALE - 1);
  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  logic [PRE_W-1:0] pre_q;

  assign tick = (pre_q == PRE_MAX);
  assign ovf  = tick && (count == CNT_TOP) && !restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      count <= '0;
    end else if (restart) begin
      pre_q <= '0;
      count <= '0;
    end else if (tick) begin
      pre_q <= '0;
      count <= count + 1'b1;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end
endmodule

// File: rtl/compare_bank.sv
module compare_bank
  import triac_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int SET_W  = 8,
  parameter int STEP   = 192,
  parameter int PULSE  = 60
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             use_setting,
  input  logic [SET_W-1:0] setting,
  input  logic [CNT_W-1:0] on_raw,
  input  logic [CNT_W-1:0] off_raw,
  input  logic             shadow_we,
  input  logic             load,
  input  logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] act_on,
  output logic [CNT_W-1:0] act_off,
  output logic             window
);
  localparam int unsigned FULL = (1 << SET_W) - 1;

  logic [CNT_W-1:0] sh_on, sh_off;
  logic [31:0]      calc_on, calc_off;

  assign calc_on  = turn_on_point(32'(setting), FULL, STEP);
  assign calc_off = calc_on + PULSE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_on  <= '0;
      sh_off <= '0;
    end else if (shadow_we) begin
      sh_on  <= use_setting ? calc_on[CNT_W-1:0]  : on_raw;
      sh_off <= use_setting ? calc_off[CNT_W-1:0] : off_raw;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_on  <= '0;
      act_off <= '0;
    end else if (load) begin
      act_on  <= sh_on;
      act_off <= sh_off;
    end
  end

  assign window = in_window(32'(count), 32'(act_on), 32'(act_off));
endmodule

// File: rtl/triac_phase_ctrl.sv
module triac_phase_ctrl #(
  parameter int CNT_W    = 16,
  parameter int SET_W    = 8,
  parameter int PRESCALE = 8,
  parameter int STEP     = 192,
  parameter int PULSE    = 60
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             zc_in,
  input  logic             use_setting,
  input  logic [SET_W-1:0] setting,
  input  logic [CNT_W-1:0] on_raw,
  input  logic [CNT_W-1:0] off_raw,
  input  logic             shadow_we,
  input  logic             xfer_hold,
  input  logic             fault_clr,
  output logic             gate_out,
  output logic             fault_flag
);
  // Named internal events, observed by the bound checker.
  logic             zc_rise;
  logic             tick;
  logic             ovf;
  logic             load;
  logic             window;
  logic             blank;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] act_on, act_off;

  zc_edge_sync u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .zc_in   (zc_in),
    .zc_rise (zc_rise)
  );

  phase_counter #(.CNT_W(CNT_W), .PRESCALE(PRESCALE)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (zc_rise),
    .count   (cnt),
    .tick    (tick),
    .ovf     (ovf)
  );

  assign load = zc_rise & ~xfer_hold;

  compare_bank #(.CNT_W(CNT_W), .SET_W(SET_W), .STEP(STEP), .PULSE(PULSE)) u_cmp (
    .clk         (clk),
    .rst_n       (rst_n),
    .use_setting (use_setting),
    .setting     (setting),
    .on_raw      (on_raw),
    .off_raw     (off_raw),
    .shadow_we   (shadow_we),
    .load        (load),
    .count       (cnt),
    .act_on      (act_on),
    .act_off     (act_off),
    .window      (window)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_flag <= 1'b0;
      blank      <= 1'b0;
    end else begin
      if (ovf)            fault_flag <= 1'b1;
      else if (fault_clr) fault_flag <= 1'b0;
      if (ovf)            blank <= 1'b1;
      else if (zc_rise)   blank <= 1'b0;
    end
  end

  assign gate_out = window & ~blank;
endmodule

// File: rtl/triac_phase_ctrl_chk.sv
module triac_phase_ctrl_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             zc_rise,
  input logic             tick,
  input logic             ovf,
  input logic             blank,
  input logic             xfer_hold,
  input logic             fault_clr,
  input logic             gate_out,
  input logic             fault_flag,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] act_on,
  input logic [CNT_W-1:0] act_off
);
  p_cnt_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    zc_rise |=> (cnt == '0));

  p_cnt_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!zc_rise && !tick) |=> $stable(cnt));

  p_gate_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    gate_out |-> (cnt >= act_on) && (cnt < act_off));

  p_no_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (act_on >= act_off) |-> !gate_out);

  p_xfer_only_zc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !zc_rise |=> $stable(act_on) && $stable(act_off));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (zc_rise && xfer_hold) |=> $stable(act_on) && $stable(act_off));

  p_fault_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> fault_flag && blank && (cnt == '0));

  p_blank_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    blank |-> !gate_out);

  p_blank_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (zc_rise && fault_flag) |=> !blank && fault_flag);

  p_fault_clr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_clr && !ovf) |=> !fault_flag);
endmodule

bind triac_phase_ctrl triac_phase_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .zc_rise    (zc_rise),
  .tick       (tick),
  .ovf        (ovf),
  .blank      (blank),
  .xfer_hold  (xfer_hold),
  .fault_clr  (fault_clr),
  .gate_out   (gate_out),
  .fault_flag (fault_flag),
  .cnt        (cnt),
  .act_on     (act_on),
  .act_off    (act_off)
);

// File: tb/triac_phase_ctrl_tb.sv
module triac_phase_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;

  typedef struct packed {
    logic        mode;
    logic [7:0]  lvl;
    logic [15:0] on_v;
    logic [15:0] off_v;
  } vec_t;

  // mode 1: window from brightness; mode 0: raw compare pair
  localparam vec_t VECS [NV] = '{
    '{1'b1, 8'd255, 16'd0,    16'd0},
    '{1'b1, 8'd254, 16'd0,    16'd0},
    '{1'b1, 8'd250, 16'd0,    16'd0},
    '{1'b0, 8'd0,   16'd100,  16'd101},
    '{1'b0, 8'd0,   16'd500,  16'd300},
    '{1'b0, 8'd0,   16'd200,  16'd200},
    '{1'b0, 8'd0,   16'd0,    16'd1},
    '{1'b0, 8'd0,   16'd1000, 16'd1300}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic zc = 1'b0, use_setting = 1'b0, we = 1'b0, hold = 1'b0, clr = 1'b0;
  logic [7:0]  lvl = '0;
  logic [15:0] on_raw = '0, off_raw = '0;
  logic gate, fault;

  logic zc_b = 1'b0, we_b = 1'b0, clr_b = 1'b0;
  logic gate_b, fault_b;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  triac_phase_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .zc_in(zc), .use_setting(use_setting),
    .setting(lvl), .on_raw(on_raw), .off_raw(off_raw), .shadow_we(we),
    .xfer_hold(hold), .fault_clr(clr), .gate_out(gate), .fault_flag(fault)
  );

  // Narrow counter so overflow arrives within the run time.
  triac_phase_ctrl #(.CNT_W(10)) dut_ov_i (
    .clk(clk), .rst_n(rst_n), .zc_in(zc_b), .use_setting(1'b0),
    .setting(8'd0), .on_raw(10'd100), .off_raw(10'd160), .shadow_we(we_b),
    .xfer_hold(1'b0), .fault_clr(clr_b), .gate_out(gate_b), .fault_flag(fault_b)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_shadow(input logic m, input logic [7:0] l,
                           input logic [15:0] a, input logic [15:0] b);
    @(negedge clk);
    use_setting = m; lvl = l; on_raw = a; off_raw = b; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  // Raises zc at t=0 and returns the negedge index of the gate's rise and fall.
  task automatic run_half(input int max_t, input int wr_t,
                          input logic [15:0] w_on, input logic [15:0] w_off,
                          output int rise_t, output int fall_t);
    rise_t = -1; fall_t = -1;
    @(negedge clk);
    zc = 1'b1;
    for (int t = 1; t <= max_t; t++) begin
      @(negedge clk);
      if (t >= 3) begin
        if (rise_t < 0 && gate) rise_t = t;
        else if (rise_t >= 0 && fall_t < 0 && !gate) fall_t = t;
      end
      if (t == 3) zc = 1'b0;
      if (t == wr_t) begin
        use_setting = 1'b0; on_raw = w_on; off_raw = w_off; we = 1'b1;
      end else begin
        we = 1'b0;
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    fails++;
    $display("FAIL R2: watchdog, actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int r, f, e_on, e_off, max_t;
    repeat (3) @(negedge clk);
    chk("R1 gate after reset", gate, 0);
    chk("R1 fault after reset", fault, 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    chk("R1 no pulse before first load", gate, 0);

    // Table walk: R2 timing, R3 window, R4 brightness, R5 raw, R6 empty window
    for (int i = 0; i < NV; i++) begin
      if (VECS[i].mode) begin
        e_on  = 48960 - 192 * int'(VECS[i].lvl);
        e_off = e_on + 60;
      end else begin
        e_on  = int'(VECS[i].on_v);
        e_off = int'(VECS[i].off_v);
      end
      max_t = 3 + 8 * ((e_on > e_off) ? e_on : e_off) + 16;
      wr_shadow(VECS[i].mode, VECS[i].lvl, VECS[i].on_v, VECS[i].off_v);
      run_half(max_t, -1, 16'd0, 16'd0, r, f);
      if (e_on < e_off) begin
        chk($sformatf("R2 R4 R5 rise vec %0d", i), r, 3 + 8 * e_on);
        chk($sformatf("R3 fall vec %0d", i), f, 3 + 8 * e_off);
      end else begin
        chk($sformatf("R6 no pulse vec %0d", i), r, -1);
      end
    end

    // R7: a write in mid half-cycle must not move this half-cycle's pulse
    wr_shadow(1'b0, 8'd0, 16'd100, 16'd160);
    run_half(1300, 10, 16'd20, 16'd30, r, f);
    chk("R7 rise unaffected by mid-cycle write", r, 803);
    chk("R7 fall unaffected by mid-cycle write", f, 1283);

    // R8: held transfer keeps the old window, release loads the new one
    hold = 1'b1;
    run_half(1300, -1, 16'd0, 16'd0, r, f);
    chk("R8 held window rise", r, 803);
    hold = 1'b0;
    run_half(300, -1, 16'd0, 16'd0, r, f);
    chk("R8 R7 released window rise", r, 163);
    chk("R8 R7 released window fall", f, 243);

    // Overflow on the narrow instance (10-bit counter, window 100..160)
    @(negedge clk); we_b = 1'b1;
    @(negedge clk); we_b = 1'b0;
    @(negedge clk); zc_b = 1'b1;
    for (int t = 1; t <= 9000; t++) begin
      @(negedge clk);
      if (t == 3) zc_b = 1'b0;
      if (t == 5) clr_b = 1'b1;
      if (t == 6) clr_b = 1'b0;
      if (t == 10)   chk("R11 fault cleared", fault_b, 0);
      if (t == 803)  chk("R3 narrow instance in window", gate_b, 1);
      if (t == 8194) chk("R9 no fault before wrap", fault_b, 0);
      if (t == 8195) chk("R9 fault at wrap", fault_b, 1);
      if (t == 9000) chk("R9 gate blanked inside window", gate_b, 0);
    end
    @(negedge clk); zc_b = 1'b1;
    for (int t = 1; t <= 810; t++) begin
      @(negedge clk);
      if (t == 3) zc_b = 1'b0;
      if (t == 803) begin
        chk("R10 gate released after zero-crossing", gate_b, 1);
        chk("R10 fault still set", fault_b, 1);
      end
    end
    @(negedge clk); clr_b = 1'b1;
    @(negedge clk); clr_b = 1'b0;
    chk("R11 fault cleared by pulse", fault_b, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule